// File: doc/BRIEF.md
# Shared-Timebase Edge-Programmed PWM Bank

This block drives up to sixteen pulse-width outputs from one common timebase. A programmable prescaler divides the input clock and produces a count tick. A period counter advances on each tick and wraps from the programmed period value back to zero, which starts the next period. Each channel does not hold a duty value. It holds two absolute count positions: one where its output is set high and one where it is cleared low. Setting both positions to the same value makes the output toggle once per period. A position beyond the period value is never reached, so the output stays constant.

Software reaches the settings through a plain byte-wide register bus with word-spaced addresses. Channels chosen at elaboration time carry a second copy of their edge settings. While the synchronous-update bit is set, writes to such a channel land in that copy and move into force only when the period counter wraps, so a period already running ends with its old shape. All other channels apply writes at once. Readback always returns the settings in force.

Top module: `pwm_bank`

## Requirements
- R1: After reset every register, every enable bit and the synchronous-update bit read as zero, and every output is low.
- R2: One period lasts (prescale+1)×(period+1) input clocks. The prescale register is at address 0x00 and the period register is at 0x04.
- R3: While a channel is enabled, its output goes high when the period count equals its set position (address 0x10+8·ch) and low when the count equals its clear position (0x14+8·ch). This holds whether the set position is below or above the clear position.
- R4: A channel whose set and clear positions are equal toggles its output on each match, giving a 50% waveform at twice the period.
- R5: A position greater than the period value never matches. Set=0 with clear=period+1 holds the output high, and the reverse holds it low.
- R6: Enable bits for channels 0–7 are at address 0x08 and those for channels 8–15 at 0x0C, at bit position ch mod 8. A disabled channel drives its output low.
- R7: A read returns the addressed register on bus_rdata one clock after the address is presented. Every register reads back the last value written to it.
- R8: With the synchronous-update bit (address 0xE4, bit 0) set, a write to a channel marked in SHADOW_MASK does not change the value read back or the waveform until the next period-counter wrap. After that wrap it does.
- R9: A channel not marked in SHADOW_MASK applies edge writes immediately, even while the synchronous-update bit is set.
- R10: With the synchronous-update bit clear, edge writes to a shadowed channel also apply immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the address of the previous cycle |
| pwm_out | output | NUM_CH | Channel outputs |

## Verification
Read data is due one clock after the address settles, so each read samples bus_rdata on the falling edge that follows one rising edge. A channel output changes one clock after the count step that matches it. The bench therefore does not predict single edges. After any setting change it waits several whole periods, then counts high cycles and rising transitions over a window that is an exact multiple of the waveform's period. This makes the expected counts independent of phase. Shadow timing is checked against a marker channel whose rising edge follows each counter wrap by two clocks. Writes issued just after that edge fall well inside a period.

// File: rtl/pwm_bank_pkg.sv
// Shared constants and helpers for the PWM bank.
// Assumes byte-wide data and byte addresses that fit in eight bits.
package pwm_bank_pkg;
    localparam int unsigned BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t ADR_PRESCALE = 8'h00;
    localparam byte_t ADR_PERIOD   = 8'h04;
    localparam byte_t ADR_EN_LO    = 8'h08;
    localparam byte_t ADR_EN_HI    = 8'h0C;
    localparam byte_t ADR_SYNC     = 8'hE4;
    localparam int unsigned EDGE_BASE   = 16;
    localparam int unsigned EDGE_STRIDE = 8;
    localparam int unsigned CLR_OFFSET  = 4;

    // Byte address of a channel's set (clr=0) or clear (clr=1) position.
    function automatic byte_t edge_addr(input int unsigned ch, input logic clr);
        return byte_t'(EDGE_BASE + EDGE_STRIDE * ch + (clr ? CLR_OFFSET : 0));
    endfunction
endpackage

// File: rtl/pwm_timebase.sv
// Shared timebase: a prescaler that wraps at 'prescale' and a period
// counter that advances once per prescaler wrap and wraps at 'period'.
// 'step' is high in the first cycle a new count value is visible.
// Assumes settings may change at any time; >= compares recover the
// counters if a setting drops below the running count.
module pwm_timebase #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] prescale,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             step,
    output logic             wrap
);
    logic [CNT_W-1:0] presc_q;
    logic             tick;

    assign tick = (presc_q >= prescale);
    assign wrap = tick && (cnt >= period);

    // Advance prescaler, period counter and the fresh-count strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
            cnt     <= '0;
            step    <= 1'b1;
        end else begin
            presc_q <= tick ? '0 : presc_q + 1'b1;
            if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
            step    <= tick;
        end
    end
endmodule

// File: rtl/pwm_channel.sv
// One output channel: active set/clear positions, optional shadow copy,
// and the output state. With HAS_SHADOW, writes made while sync_en is
// set wait in the shadow copy until the next counter wrap.
// Assumes at most one of wr_set/wr_clr per cycle.
module pwm_channel #(
    parameter int unsigned CNT_W      = 8,
    parameter bit          HAS_SHADOW = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    input  logic             sync_en,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] act_set,
    output logic [CNT_W-1:0] act_clr,
    output logic             out
);
    generate
        if (HAS_SHADOW) begin : g_shadow
            logic [CNT_W-1:0] sh_set, sh_clr;
            // Shadow copy follows writes; active copy loads at wrap or directly.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sh_set  <= '0;
                    sh_clr  <= '0;
                    act_set <= '0;
                    act_clr <= '0;
                end else begin
                    if (wrap) begin
                        act_set <= sh_set;
                        act_clr <= sh_clr;
                    end
                    if (wr_set) begin
                        sh_set <= wdata;
                        if (!sync_en) act_set <= wdata;
                    end
                    if (wr_clr) begin
                        sh_clr <= wdata;
                        if (!sync_en) act_clr <= wdata;
                    end
                end
            end
        end else begin : g_direct
            // Writes go straight into the active positions.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    act_set <= '0;
                    act_clr <= '0;
                end else begin
                    if (wr_set) act_set <= wdata;
                    if (wr_clr) act_clr <= wdata;
                end
            end
        end
    endgenerate

    // Output state: cleared when disabled, updated once per fresh count.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            out <= 1'b0;
        end else if (step) begin
            if (cnt == act_set && cnt == act_clr) out <= ~out;
            else if (cnt == act_set)              out <= 1'b1;
            else if (cnt == act_clr)              out <= 1'b0;
        end
    end
endmodule

// File: rtl/pwm_bank.sv
// Top of the PWM bank: register decode, readback, timebase and channels.
// Assumes 1 <= NUM_CH <= 16 and that all edge addresses fit in ADDR_W.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int unsigned NUM_CH      = 16,
    parameter int unsigned ADDR_W      = 8,
    parameter logic [15:0] SHADOW_MASK = 16'h00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int unsigned CNT_W = BYTE_W;
    localparam int unsigned EN_W  = 2 * BYTE_W;

    logic [CNT_W-1:0]             prescale_q, period_q, cnt;
    logic                         sync_en, step, wrap;
    logic [NUM_CH-1:0]            chan_en;
    logic [EN_W-1:0]              en_full;
    logic [NUM_CH-1:0][CNT_W-1:0] act_set, act_clr;
    logic [NUM_CH-1:0]            wr_set, wr_clr;
    logic [7:0]                   rd_mux;

    // Global settings and enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prescale_q <= '0;
            period_q   <= '0;
            sync_en    <= 1'b0;
            chan_en    <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(ADR_PRESCALE)) prescale_q <= bus_wdata;
            if (bus_addr == ADDR_W'(ADR_PERIOD))   period_q   <= bus_wdata;
            if (bus_addr == ADDR_W'(ADR_SYNC))     sync_en    <= bus_wdata[0];
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == ADDR_W'((i < 8) ? ADR_EN_LO : ADR_EN_HI))
                    chan_en[i] <= bus_wdata[i % 8];
            end
        end
    end

    // Zero-extended enable vector for the two enable registers.
    always_comb begin
        en_full = '0;
        en_full[NUM_CH-1:0] = chan_en;
    end

    // Readback selector over all registers.
    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(ADR_PRESCALE)) rd_mux = prescale_q;
        if (bus_addr == ADDR_W'(ADR_PERIOD))   rd_mux = period_q;
        if (bus_addr == ADDR_W'(ADR_EN_LO))    rd_mux = en_full[7:0];
        if (bus_addr == ADDR_W'(ADR_EN_HI))    rd_mux = en_full[15:8];
        if (bus_addr == ADDR_W'(ADR_SYNC))     rd_mux = {7'b0, sync_en};
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(edge_addr(i, 1'b0))) rd_mux = act_set[i];
            if (bus_addr == ADDR_W'(edge_addr(i, 1'b1))) rd_mux = act_clr[i];
        end
    end

    // Registered read data, one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_mux;
    end

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .prescale(prescale_q), .period(period_q),
        .cnt(cnt), .step(step), .wrap(wrap)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            assign wr_set[g] = bus_wr && (bus_addr == ADDR_W'(edge_addr(g, 1'b0)));
            assign wr_clr[g] = bus_wr && (bus_addr == ADDR_W'(edge_addr(g, 1'b1)));
            pwm_channel #(.CNT_W(CNT_W), .HAS_SHADOW(SHADOW_MASK[g])) u_ch (
                .clk(clk), .rst_n(rst_n), .en(chan_en[g]), .step(step),
                .wrap(wrap), .cnt(cnt), .sync_en(sync_en),
                .wr_set(wr_set[g]), .wr_clr(wr_clr[g]), .wdata(bus_wdata),
                .act_set(act_set[g]), .act_clr(act_clr[g]), .out(pwm_out[g])
            );
        end
    endgenerate
endmodule

// File: rtl/pwm_bank_checker.sv
// Temporal checks on the PWM bank, bound to every pwm_bank instance.
// Assumes the internal signal names of pwm_bank.
module pwm_bank_checker #(
    parameter int unsigned NUM_CH      = 16,
    parameter logic [15:0] SHADOW_MASK = 16'h00FF
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_CH-1:0]      pwm_out,
    input logic [NUM_CH-1:0]      chan_en,
    input logic                   step,
    input logic                   wrap,
    input logic [7:0]             cnt,
    input logic                   sync_en,
    input logic [NUM_CH-1:0][7:0] act_set,
    input logic [NUM_CH-1:0][7:0] act_clr
);
    // R6: a channel disabled last cycle is low now.
    assert_disabled_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_out & ~$past(chan_en)) == '0);

    // R2: a wrap event restarts the period count at zero.
    assert_wrap_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == 8'd0));

    // R3: an enabled output changes only after a fresh count value.
    assert_edge_on_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (((pwm_out ^ $past(pwm_out)) & $past(chan_en)) != '0) |-> $past(step));

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_sh
            if (SHADOW_MASK[g]) begin : g_on
                // R8: in synchronous mode active positions move only at a wrap.
                assert_set_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                    ($past(sync_en) && !$past(wrap)) |-> $stable(act_set[g]));
                assert_clr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                    ($past(sync_en) && !$past(wrap)) |-> $stable(act_clr[g]));
            end
        end
    endgenerate
endmodule

bind pwm_bank pwm_bank_checker #(.NUM_CH(NUM_CH), .SHADOW_MASK(SHADOW_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .chan_en(chan_en),
    .step(step), .wrap(wrap), .cnt(cnt), .sync_en(sync_en),
    .act_set(act_set), .act_clr(act_clr)
);

// File: tb/pwm_bank_test.sv
`timescale 1ns/1ps
// Scoreboard bench: tasks queue expected values, result producers pop and compare.
module pwm_bank_test;
    localparam int unsigned NUM_CH = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic [NUM_CH-1:0] pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string tag;
        int    val;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    pwm_bank #(.NUM_CH(NUM_CH), .ADDR_W(8), .SHADOW_MASK(16'h00FF)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic expect_val(input string tag, input int val);
        exp_t e;
        e.tag = tag;
        e.val = val;
        exp_q.push_back(e);
    endtask

    task automatic compare(input int got);
        exp_t e;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL scoreboard empty: actual %0d expected none", got);
        end else begin
            e = exp_q.pop_front();
            if (got != e.val) begin
                fails++;
                $display("FAIL %s: actual %0d expected %0d", e.tag, got, e.val);
            end
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [7:0] a, input int val);
        expect_val(tag, val);
        @(negedge clk);
        bus_addr = a;
        @(negedge clk);
        compare(int'(bus_rdata));
    endtask

    // Count high samples and rising transitions over w cycles.
    task automatic wave_check(input string tag, input int ch, input int w,
                              input int exp_hi, input int exp_rise);
        logic prev;
        int hi = 0;
        int rises = 0;
        expect_val({tag, " high"}, exp_hi);
        expect_val({tag, " rises"}, exp_rise);
        @(negedge clk);
        prev = pwm_out[ch];
        for (int k = 0; k < w; k++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
            if (pwm_out[ch] && !prev) rises++;
            prev = pwm_out[ch];
        end
        compare(hi);
        compare(rises);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        expect_val("R1 outputs low", 0);
        compare(int'(pwm_out));
        read_check("R1 prescale", 8'h00, 0);
        read_check("R1 period", 8'h04, 0);
        read_check("R1 enable low", 8'h08, 0);
        read_check("R1 enable high", 8'h0C, 0);
        read_check("R1 sync", 8'hE4, 0);
        read_check("R1 ch0 set", 8'h10, 0);

        // R7: readback of written registers
        bus_write(8'h00, 8'h5A);
        read_check("R7 prescale", 8'h00, 8'h5A);
        bus_write(8'h04, 8'hA5);
        read_check("R7 period", 8'h04, 8'hA5);
        bus_write(8'h8C, 8'h3C);
        read_check("R7 ch15 clear", 8'h8C, 8'h3C);
        bus_write(8'h50, 8'h11);
        read_check("R7 ch8 set", 8'h50, 8'h11);
        bus_write(8'hE4, 8'h01);
        read_check("R7 sync", 8'hE4, 1);
        bus_write(8'hE4, 8'h00);

        // R3: ch8 (unshadowed), prescale 0, period 15 -> 16 clocks
        bus_write(8'h00, 8'd0);
        bus_write(8'h04, 8'd15);
        bus_write(8'h0C, 8'h01);
        read_check("R6 enable high", 8'h0C, 1);
        bus_write(8'h50, 8'd2);
        bus_write(8'h54, 8'd7);
        settle(64);
        wave_check("R3 set below clear", 8, 64, 20, 4);
        bus_write(8'h50, 8'd10);
        bus_write(8'h54, 8'd3);
        settle(64);
        wave_check("R3 set above clear", 8, 64, 36, 4);

        // R2: prescale 2 -> period 48 clocks, high 5*3 per period
        bus_write(8'h50, 8'd2);
        bus_write(8'h54, 8'd7);
        bus_write(8'h00, 8'd2);
        settle(150);
        wave_check("R2 prescaled period", 8, 96, 30, 2);
        bus_write(8'h00, 8'd0);

        // R4: equal positions toggle once per 16-clock period
        bus_write(8'h50, 8'd5);
        bus_write(8'h54, 8'd5);
        settle(100);
        wave_check("R4 equal edges", 8, 64, 32, 2);

        // R5: out-of-range positions hold the output
        bus_write(8'h50, 8'd0);
        bus_write(8'h54, 8'd16);
        settle(64);
        wave_check("R5 held high", 8, 64, 64, 0);
        bus_write(8'h50, 8'd16);
        bus_write(8'h54, 8'd0);
        settle(64);
        wave_check("R5 held low", 8, 64, 0, 0);

        // R6: enable mapping and disabled output low
        bus_write(8'h50, 8'd0);
        bus_write(8'h54, 8'd16);
        bus_write(8'h0C, 8'h02);
        settle(64);
        wave_check("R6 ch8 disabled", 8, 64, 0, 0);
        wave_check("R6 ch9 enabled toggles", 9, 64, 32, 2);
        bus_write(8'h0C, 8'h01);
        settle(64);
        wave_check("R6 ch8 re-enabled", 8, 64, 64, 0);

        // R8: shadowed ch0, marker ch1 rises right after each wrap
        bus_write(8'h00, 8'd3);
        bus_write(8'h04, 8'd20);
        bus_write(8'h18, 8'd0);
        bus_write(8'h1C, 8'd10);
        bus_write(8'h10, 8'd3);
        bus_write(8'h08, 8'h02);
        read_check("R6 enable low", 8'h08, 2);
        bus_write(8'hE4, 8'h01);
        @(posedge pwm_out[1]);
        bus_write(8'h10, 8'd9);
        read_check("R8 pending not visible", 8'h10, 3);
        // R9: unshadowed ch8 applies at once in synchronous mode
        bus_write(8'h50, 8'd7);
        read_check("R9 immediate", 8'h50, 7);
        @(posedge pwm_out[1]);
        settle(3);
        read_check("R8 applied after wrap", 8'h10, 9);

        // R10: synchronous mode off, shadowed ch0 applies at once
        bus_write(8'hE4, 8'h00);
        @(posedge pwm_out[1]);
        settle(2);
        bus_write(8'h14, 8'd11);
        read_check("R10 immediate", 8'h14, 11);

        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule